// File: doc/BRIEF.md
# Fixed-Direction GPIO Controller with Edge Interrupts

This block is a small register-mapped general-purpose I/O controller with eight pins behind a byte-wide register bus. The lower half of the pins always drive. The upper half are always sampled. Direction is fixed in hardware. A direction register can still be read and written, but its value never changes which pins drive. Input pins pass through a two-flop synchroniser before the block uses them.

Each input pin has its own two-bit edge-select field. One bit of the field arms rising-edge capture and the other arms falling-edge capture. A field of zero disables the pin. A captured edge sets a sticky pending bit. Software clears a pending bit by writing a one to it. A single level interrupt line is asserted while any pending bit is set. Software reads the pending bits, writes the same value back to acknowledge them, and then reads the data register to see the live input levels.

Top module: `gpio_fixdir_top`

## Requirements
- R1: After reset, output pins are 0, the edge-select register (offset 3) reads 0x00, the pending register (offset 4) reads 0x00, the direction register (offset 0) reads 0x0F, and the interrupt output is low.
- R2: Writing offset 1 updates the output pins from data bits 3:0 at the next clock. Bits 7:4 of the write are ignored. A read of offset 1 returns the output latch in bits 3:0 and the synchronised input levels in bits 7:4.
- R3: Pin inputs reach the synchronised value after two clocks. An edge is detected by comparing the synchronised value with its value one cycle earlier.
- R4: Input k (pin k+4) uses edge-select bits [2k+1:2k]. Bit 2k arms falling-edge capture and bit 2k+1 arms rising-edge capture. When both are set, either edge is captured. A field of 00 captures nothing.
- R5: Pending bit k (offset 4, bits 3:0) sets on an armed edge of input k. Writing a 1 to a bit clears it, and writing 0 leaves it unchanged. Bits 7:4 always read 0.
- R6: If a clearing write and a new armed edge hit the same pending bit in the same cycle, the bit stays set.
- R7: The interrupt output is high exactly while any pending bit is set.
- R8: Output pins never raise an interrupt, and writes to the direction register (offset 0) never change the output pins. The direction register holds its written value.
- R9: Reads of offset 2 and of offsets 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 4 | Asynchronous input pins (pins 4 to 7) |
| pin_out | output | 4 | Output pins (pins 0 to 3) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a clearing write to a pending bit that lands in the same cycle as a fresh armed edge on that input. The synchroniser delay makes that cycle hard to hit. The bench changes the pin exactly two clocks before the intended detection edge and issues the clearing write so that both act at the same clock. It then reads the pending register to confirm the bit survived. A behavioural model reproduces the synchroniser delay with a queue, and the bench compares output pins, interrupt and read data against it every cycle under random pin and bus traffic.

// File: rtl/gpio_fixdir_pkg.sv
// Package: shared constants and offsets for the fixed-direction GPIO block.
package gpio_fixdir_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int N_OUT    = 4;
    localparam int N_IN     = 4;
    localparam int SEL_W    = 2;
    localparam logic [ADDR_W-1:0] OFF_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ESEL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_PEND = 3'd4;
    localparam logic [DATA_W-1:0] DIR_INIT = 8'h0F;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser plus a one-cycle history register.
// Assumes: inputs are asynchronous; outputs the current and previous synced levels.
module gpio_in_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_now,
    output logic [WIDTH-1:0] sync_prev
);
    logic [WIDTH-1:0] meta_q;

    // Purpose: move asynchronous levels into the clock domain and keep a one-cycle history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_now  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= raw_in;
            sync_now  <= meta_q;
            sync_prev <= sync_now;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
// Module: per-input edge qualification against a 2-bit select field.
// Assumes: field bit 0 arms falling, bit 1 arms rising; 00 disables the input.
module gpio_edge_detect #(
    parameter int N_IN  = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_IN-1:0]       cur,
    input  logic [N_IN-1:0]       prev,
    input  logic [N_IN*SEL_W-1:0] esel,
    output logic [N_IN-1:0]       hit
);
    // Purpose: build one qualifier per input.
    for (genvar k = 0; k < N_IN; k++) begin : g_edge
        logic rise, fall;
        // Purpose: find the edge direction and gate it with the field bits.
        always_comb begin
            rise   = cur[k] & ~prev[k];
            fall   = ~cur[k] & prev[k];
            hit[k] = (rise & esel[SEL_W*k+1]) | (fall & esel[SEL_W*k]);
        end
    end
endmodule

// File: rtl/gpio_pend_reg.sv
// Module: sticky pending bits, cleared by writing ones; a new edge beats a clear.
// Assumes: clr_mask is valid only in the cycle of the write.
module gpio_pend_reg #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] set_mask,
    input  logic [N_IN-1:0] clr_mask,
    output logic [N_IN-1:0] pend,
    output logic            any_pend
);
    // Purpose: hold pending edges with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | set_mask;
    end

    // Purpose: merge the pending bits into one level interrupt.
    always_comb any_pend = |pend;
endmodule

// File: rtl/gpio_fixdir_top.sv
// Module: eight-pin GPIO controller; low half fixed outputs, high half fixed
// inputs with edge interrupts. Assumes a single-cycle register bus with
// combinational read data and writes taking effect at the clock edge.
module gpio_fixdir_top
    import gpio_fixdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_OUT-1:0]  pin_out,
    output logic              irq
);
    localparam int ESEL_W = N_IN * SEL_W;

    logic [DATA_W-1:0] dir_q;
    logic [N_OUT-1:0]  out_q;
    logic [ESEL_W-1:0] esel_q;
    logic [N_IN-1:0]   in_now, in_prev, edge_hit, pend_q, pend_clr;
    logic              wr_dir, wr_data, wr_esel, wr_pend;

    // Purpose: decode the write strobes.
    always_comb begin
        wr_dir  = bus_wr && (bus_addr == OFF_DIR);
        wr_data = bus_wr && (bus_addr == OFF_DATA);
        wr_esel = bus_wr && (bus_addr == OFF_ESEL);
        wr_pend = bus_wr && (bus_addr == OFF_PEND);
    end

    // Purpose: hold the direction register, the output latch and the edge-select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= DIR_INIT;
            out_q  <= '0;
            esel_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_data) out_q  <= bus_wdata[N_OUT-1:0];
            if (wr_esel) esel_q <= bus_wdata[ESEL_W-1:0];
        end
    end

    gpio_in_sync #(.WIDTH(N_IN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
        .sync_now(in_now), .sync_prev(in_prev)
    );

    gpio_edge_detect #(.N_IN(N_IN), .SEL_W(SEL_W)) u_edge (
        .cur(in_now), .prev(in_prev), .esel(esel_q), .hit(edge_hit)
    );

    // Purpose: form the clear mask from a write-one-to-clear access.
    always_comb pend_clr = wr_pend ? bus_wdata[N_IN-1:0] : '0;

    gpio_pend_reg #(.N_IN(N_IN)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_mask(edge_hit), .clr_mask(pend_clr),
        .pend(pend_q), .any_pend(irq)
    );

    // Purpose: select the read data by offset; unused offsets read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_DIR:  bus_rdata = dir_q;
            OFF_DATA: bus_rdata = {in_now, out_q};
            OFF_ESEL: bus_rdata = esel_q;
            OFF_PEND: bus_rdata = {{(DATA_W-N_IN){1'b0}}, pend_q};
            default:  bus_rdata = '0;
        endcase
    end

    // Purpose: drive the output pins from the latch alone; direction is fixed.
    always_comb pin_out = out_q;
endmodule

// File: rtl/gpio_fixdir_chk.sv
// Module: property checker for gpio_fixdir_top, attached with bind.
module gpio_fixdir_chk
    import gpio_fixdir_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_OUT-1:0]  pin_out,
    input logic              irq,
    input logic [N_IN-1:0]   pend_q,
    input logic [N_IN-1:0]   edge_hit
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_out == '0 && !irq));

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DATA) |=> pin_out == $past(bus_wdata[N_OUT-1:0]));

    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFF_DATA) |=> $stable(pin_out));

    assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_q != '0));

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2 || bus_addr > 3'd4) |-> bus_rdata == '0);
endmodule

bind gpio_fixdir_top gpio_fixdir_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .irq(irq), .pend_q(pend_q), .edge_hit(edge_hit)
);

// File: tb/sim_gpio_fixdir_top.sv
module sim_gpio_fixdir_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = 0;
    logic [3:0] pin_out;
    logic       irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state
    int m_out, m_esel, m_pend, m_dir;
    int m_meta, m_now, m_prev;

    gpio_fixdir_top u0 (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_dir;
            1: return ((m_now & 15) << 4) | m_out;
            3: return m_esel;
            4: return m_pend;
            default: return 0;
        endcase
    endfunction

    // Model update at each clock, from the inputs present before the edge
    always @(posedge clk) begin
        int hit, a, w;
        a = bus_addr; w = bus_wdata;
        if (!rst_n) begin
            m_out = 0; m_esel = 0; m_pend = 0; m_dir = 'h0F;
            m_meta = 0; m_now = 0; m_prev = 0;
        end else begin
            hit = 0;
            for (int k = 0; k < 4; k++) begin
                int c, p;
                c = (m_now >> k) & 1; p = (m_prev >> k) & 1;
                if (c && !p && ((m_esel >> (2*k+1)) & 1)) hit |= 1 << k;
                if (!c && p && ((m_esel >> (2*k)) & 1)) hit |= 1 << k;
            end
            if (bus_wr && a == 4) m_pend = m_pend & ~(w & 15);
            m_pend = m_pend | hit;
            if (bus_wr && a == 0) m_dir = w;
            if (bus_wr && a == 1) m_out = w & 15;
            if (bus_wr && a == 3) m_esel = w;
            m_prev = m_now; m_now = m_meta; m_meta = pin_in;
        end
    end

    // Every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 pin_out", pin_out, m_out);
            check("R7 irq", irq, m_pend != 0);
            check("R9/R2 rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1; bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(posedge clk); #1; bus_wr = 0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        @(posedge clk); #1; bus_addr = a; bus_wr = 0;
        @(negedge clk); check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        rd_check("R1 dir", 0, 'h0F);
        rd_check("R1 esel", 3, 0);
        rd_check("R1 pend", 4, 0);
        check("R1 out", pin_out, 0);
        check("R1 irq", irq, 0);
        // R2 data write, upper bits ignored
        wr(1, 'hA5);
        check("R2 out", pin_out, 5);
        pin_in = 4'b1010; idle(4);
        rd_check("R2/R3 data read", 1, 'hA5);
        // R8 direction writes do not change outputs
        wr(0, 'h00);
        check("R8 out kept", pin_out, 5);
        rd_check("R8 dir holds", 0, 0);
        // R4 masked: edges with esel=0 set nothing
        pin_in = 0; idle(4);
        rd_check("R4 masked", 4, 0);
        // R4 rising-only on input 0, falling-only on input 1, both on 2
        wr(3, 8'b0011_0110);
        pin_in = 4'b0001; idle(4);
        rd_check("R4 rise in0", 4, 1);
        check("R7 irq on", irq, 1);
        pin_in = 4'b0010; idle(4);   // in0 falls (not armed), in1 rises (not armed)
        rd_check("R4 fall unarmed", 4, 1);
        pin_in = 4'b0000; idle(4);   // in1 falls -> armed
        rd_check("R4 fall in1", 4, 3);
        pin_in = 4'b0100; idle(4);
        pin_in = 4'b0000; idle(4);
        rd_check("R4 both in2", 4, 7);
        // R5 write-one-to-clear, zeros leave bits
        wr(4, 'hF2);
        rd_check("R5 w1c", 4, 5);
        wr(4, 5);
        rd_check("R5 cleared", 4, 0);
        check("R7 irq off", irq, 0);
        // R6 collision: pin change two clocks ahead of the clear
        pin_in = 4'b0001; idle(4);   // sets pend bit0
        pin_in = 4'b0000;             // falls; in0 is rising-only, so use rise
        idle(4);
        wr(4, 1);                     // now clear
        @(posedge clk); #1;
        pin_in = 4'b0001;             // sampled at edge A
        @(posedge clk); #1;           // edge A: meta
        @(posedge clk); #1;           // edge B: now=1, detection comb
        // hit pends at edge C, so pend must be set first; then collide at C
        idle(2);
        rd_check("R6 pre-set", 4, 1);
        pin_in = 0; idle(4);
        @(posedge clk); #1; pin_in = 4'b0001;
        @(posedge clk); #1;           // meta captured
        bus_addr = 4; bus_wr = 1; bus_wdata = 1;
        @(posedge clk); #1;           // now captured; hit live next edge
        @(posedge clk); #1; bus_wr = 0; // clear and edge at same edge
        rd_check("R6 edge wins", 4, 1);
        // R8 outputs never raise interrupts
        wr(4, 'hF); wr(3, 0);
        for (int i = 0; i < 16; i++) wr(1, i);
        check("R8 no irq", irq, 0);
        // R9 unused offsets
        rd_check("R9 off2", 2, 0);
        rd_check("R9 off5", 5, 0);
        rd_check("R9 off7", 7, 0);
        // Random traffic with model comparison
        wr(3, 'hFF);
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            pin_in   = $urandom;
            bus_addr = $urandom_range(0, 7);
            bus_wr   = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom;
        end
        @(posedge clk); #1; bus_wr = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule